// File: doc/BRIEF.md
# Binary32 Floating-Point Multiplier

This block multiplies two single-precision binary floating-point operands and returns the rounded product together with overflow, underflow and inexact flags. A one-bit mode input selects between round-to-nearest-even and round-toward-zero. Operands use the usual binary32 layout: sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0.

Subnormal operands are brought to normal form before the significand multiply. The 48-bit significand product is placed in a 64-bit field, and its low half is folded into one sticky bit. A single left shift then normalises it, and a shared rounding and packing stage produces the result. A zero operand wins over an infinite one and gives a signed zero. An infinite operand is pushed through the rounding stage as an out-of-range exponent, so it always reports overflow and inexact.

A parameter selects either a purely combinational path or a two-stage pipeline. The pipeline cuts between the multiply and the rounding step and registers the outputs. Each stage carries a valid bit.

Top module: `fmul_sp`

## Requirements
- R1: The result sign (bit 31) is always the XOR of the operand signs.
- R2: If either operand has bits 30:0 all zero, the result is a signed zero with all three flags clear, even when the other operand is infinite.
- R3: If neither operand is zero and one has exponent 255 with a zero fraction, overflow and inexact are set and underflow is clear. The magnitude is 0x7F800000 in nearest mode (rnd_mode=0) and 0x7F7FFFFF in toward-zero mode (rnd_mode=1).
- R4: A subnormal operand (exponent field 0, non-zero fraction) takes its exact value, fraction times 2^-149, in the product.
- R5: In nearest mode a finite non-zero product equals the exact product rounded to the nearest binary32 value.
- R6: In nearest mode a product that lies exactly halfway between two representable values rounds to the one with an even fraction.
- R7: In toward-zero mode a finite product is truncated in magnitude.
- R8: Products below the normal range come out as subnormals or zero. Underflow is set when the result is tiny and inexact. Tiny means the product, rounded to 24 bits with an unbounded exponent, is below 2^-126.
- R9: When the rounded biased exponent would reach 255, overflow and inexact are set, and the result is encoded as in R3.
- R10: Inexact is set exactly when the returned value differs from the exact product.
- R11: With the pipeline enabled, out_valid and the result appear two clock edges after in_valid and the operands are presented. In the combinational variant they follow with no delay.
- R12: A synchronous active-high reset clears out_valid, the result and the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| rnd_mode | input | 1 | 0 = nearest-even, 1 = toward zero |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Rounded product, binary32 |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_inx | output | 1 | Inexact |

## Verification
The assertions assume that no operand is a NaN, meaning exponent 255 with a non-zero fraction, since NaN handling is out of scope. The timing checks also assume that the reset input is driven to a known level from the first clock edge. The random generator builds operands from exponent classes: zero, infinity, subnormal, low and high exponents, and arbitrary normal values. It never pairs exponent 255 with a non-zero fraction, so every applied operand lies inside those assumptions. The low and high exponent classes steer many products into the underflow and overflow regions. Directed ties and subnormal cases cover the points that random draws rarely hit.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    localparam int WW     = 32;            // storage word width
    localparam int EW     = 8;             // exponent field width
    localparam int FW     = 23;            // fraction field width
    localparam int SW     = FW + 1;        // significand with hidden bit
    localparam int XW     = 12;            // internal signed exponent width
    localparam int RW     = 32;            // rounding field width
    localparam int GB     = 7;             // guard bits below the kept LSB
    localparam int BIAS   = (1 << (EW - 1)) - 1;
    localparam int EXP_MAX = (1 << EW) - 1;
    localparam int OVF_EXP = EXP_MAX - 2;
    localparam int PLACE  = 2 * RW - 1 - 2 * SW;   // left offset of raw product
    localparam int LZ_W   = $clog2(FW + 2);

    typedef enum logic {
        RND_NEAR = 1'b0,
        RND_ZERO = 1'b1
    } rnd_e;

    typedef struct packed {
        logic                 sign;
        logic                 is_zero;
        logic                 is_inf;
        logic signed [XW-1:0] exp;
        logic [SW-1:0]        sig;
    } opnd_t;

    typedef struct packed {
        logic                 sign;
        logic                 zero;
        rnd_e                 mode;
        logic signed [XW-1:0] exp;
        logic [RW-1:0]        sig;
    } mid_t;

    typedef struct packed {
        logic [WW-1:0] word;
        logic          ovf;
        logic          unf;
        logic          inx;
    } res_t;

    // number of zero bits above the most significant one of a fraction
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [FW-1:0] f);
        logic [LZ_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = FW - 1; i >= 0; i--) begin
            if (f[i])
                seen = 1'b1;
            else if (!seen)
                n = n + 1'b1;
        end
        return n;
    endfunction

    // right shift that ORs every dropped bit into bit 0
    function automatic logic [RW-1:0] shr_sticky(input logic [RW-1:0] a,
                                                 input logic [XW-1:0] cnt);
        logic [RW-1:0] mask;
        if (cnt == '0)
            return a;
        if (cnt < XW'(RW)) begin
            mask = (RW'(1) << cnt) - RW'(1);
            return (a >> cnt) | RW'(|(a & mask));
        end
        return RW'(|a);
    endfunction

endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
    import fmul_pkg::*;
(
    input  logic [WW-1:0] word,
    output opnd_t         op
);
    logic [EW-1:0]   efield;
    logic [FW-1:0]   frac;
    logic [LZ_W-1:0] lsh;

    assign efield = word[WW-2 -: EW];
    assign frac   = word[FW-1:0];

    always_comb begin
        op.sign    = word[WW-1];
        op.is_zero = (efield == '0) && (frac == '0);
        op.is_inf  = (efield == '1) && (frac == '0);
        lsh        = lead_zeros(frac) + 1'b1;
        if (efield == '0) begin
            op.sig = {1'b0, frac} << lsh;
            op.exp = XW'(1) - XW'(lsh);
        end else begin
            op.sig = {1'b1, frac};
            op.exp = XW'(efield);
        end
    end
endmodule

// File: rtl/fmul_core.sv
module fmul_core
    import fmul_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    input  rnd_e  mode,
    output mid_t  m
);
    logic [2*SW-1:0]      raw;
    logic [2*RW-1:0]      wide;
    logic [RW-1:0]        folded;
    logic signed [XW-1:0] esum;

    assign raw    = a.sig * b.sig;
    assign wide   = (2*RW)'(raw) << PLACE;
    assign folded = {wide[2*RW-1:RW+1], wide[RW] | (|wide[RW-1:0])};
    assign esum   = a.exp + b.exp - XW'(BIAS);

    always_comb begin
        m.sign = a.sign ^ b.sign;
        m.mode = mode;
        m.zero = a.is_zero || b.is_zero;
        if (a.is_inf || b.is_inf) begin
            m.exp = XW'(EXP_MAX);
            m.sig = '0;
        end else if (!folded[RW-2]) begin
            m.exp = esum - XW'(1);
            m.sig = folded << 1;
        end else begin
            m.exp = esum;
            m.sig = folded;
        end
    end
endmodule

// File: rtl/fmul_round.sv
module fmul_round
    import fmul_pkg::*;
(
    input  mid_t m,
    output res_t r
);
    localparam logic signed [XW-1:0] OVF_E = XW'(OVF_EXP);
    localparam logic [RW-1:0]        HALF  = RW'(1) << (GB - 1);

    logic                 near;
    logic [RW-1:0]        inc;
    logic [RW-1:0]        probe;
    logic                 ovf_hit;
    logic                 tiny;
    logic [RW-1:0]        sig_w;
    logic signed [XW-1:0] e_w;
    logic [XW-1:0]        neg_e;
    logic [GB-1:0]        rbits;
    logic [RW:0]          rsum;
    logic [RW-GB:0]       frac_r;
    logic [WW-1:0]        packed_w;

    always_comb begin
        near    = (m.mode == RND_NEAR);
        inc     = near ? HALF : '0;
        probe   = m.sig + inc;
        ovf_hit = (m.exp > OVF_E) || ((m.exp == OVF_E) && probe[RW-1]);
        tiny    = 1'b0;
        sig_w   = m.sig;
        e_w     = m.exp;
        neg_e   = -m.exp;
        if (m.exp < 0) begin
            tiny  = (m.exp < -1) || !probe[RW-1];
            sig_w = shr_sticky(m.sig, neg_e);
            e_w   = '0;
        end
        rbits  = sig_w[GB-1:0];
        rsum   = {1'b0, sig_w} + {1'b0, inc};
        frac_r = rsum[RW:GB];
        if (near && (rbits == HALF[GB-1:0]))
            frac_r[0] = 1'b0;
        if (frac_r == '0)
            e_w = '0;
        packed_w = {m.sign, {(WW-1){1'b0}}} + (WW'(e_w[EW-1:0]) << FW) + WW'(frac_r);

        if (m.zero) begin
            r.word = {m.sign, {(WW-1){1'b0}}};
            r.ovf  = 1'b0;
            r.unf  = 1'b0;
            r.inx  = 1'b0;
        end else if (ovf_hit) begin
            r.word = {m.sign, {EW{1'b1}}, {FW{1'b0}}} - WW'(!near);
            r.ovf  = 1'b1;
            r.unf  = 1'b0;
            r.inx  = 1'b1;
        end else begin
            r.word = packed_w;
            r.ovf  = 1'b0;
            r.inx  = (rbits != '0);
            r.unf  = tiny && (rbits != '0);
        end
    end
endmodule

// File: rtl/fmul_sp.sv
module fmul_sp
    import fmul_pkg::*;
#(
    parameter bit PIPELINED = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [WW-1:0] op_a,
    input  logic [WW-1:0] op_b,
    input  logic          rnd_mode,
    output logic          out_valid,
    output logic [WW-1:0] result,
    output logic          flag_ovf,
    output logic          flag_unf,
    output logic          flag_inx
);
    opnd_t ua, ub;
    mid_t  mid_d, mid_use;
    res_t  res_d, res_o;

    fmul_unpack u_ua (.word(op_a), .op(ua));
    fmul_unpack u_ub (.word(op_b), .op(ub));

    fmul_core u_core (
        .a    (ua),
        .b    (ub),
        .mode (rnd_e'(rnd_mode)),
        .m    (mid_d)
    );

    fmul_round u_rnd (.m(mid_use), .r(res_d));

    generate
        if (PIPELINED) begin : g_pipe
            mid_t mid_q;
            logic v_q;
            res_t res_q;
            logic ov_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q   <= 1'b0;
                    mid_q <= '0;
                end else begin
                    v_q <= in_valid;
                    if (in_valid)
                        mid_q <= mid_d;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    ov_q  <= 1'b0;
                    res_q <= '0;
                end else begin
                    ov_q <= v_q;
                    if (v_q)
                        res_q <= res_d;
                end
            end

            assign mid_use   = mid_q;
            assign res_o     = res_q;
            assign out_valid = ov_q;

            // R1
            sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> result[WW-1] == $past(op_a[WW-1] ^ op_b[WW-1], 2));
            // R2
            zero_first_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid && $past((op_a[WW-2:0] == '0) || (op_b[WW-2:0] == '0), 2)
                |-> (result[WW-2:0] == '0) && !flag_ovf && !flag_unf && !flag_inx);
            // R3
            inf_operand_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid && $past((op_a[WW-2:0] != '0) && (op_b[WW-2:0] != '0) &&
                    ((op_a[WW-2:0] == 31'h7F800000) || (op_b[WW-2:0] == 31'h7F800000)), 2)
                |-> flag_ovf && flag_inx && !flag_unf &&
                    (result[WW-2:0] == ($past(rnd_mode, 2) ? 31'h7F7FFFFF : 31'h7F800000)));
            // R11
            latency_fwd_chk: assert property (@(posedge clk) disable iff (rst)
                $past(in_valid, 2) && !$past(rst, 1) && !$past(rst, 2) |-> out_valid);
            // R11
            latency_back_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> $past(in_valid, 2));
            // R12
            reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> !out_valid && (result == '0) && !flag_ovf && !flag_unf && !flag_inx);
        end else begin : g_comb
            assign mid_use   = mid_d;
            assign res_o     = res_d;
            assign out_valid = in_valid;
        end
    endgenerate

    assign result   = res_o.word;
    assign flag_ovf = res_o.ovf;
    assign flag_unf = res_o.unf;
    assign flag_inx = res_o.inx;

    // R8
    unf_has_inx_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && flag_unf |-> flag_inx && !flag_ovf);
    // R9
    ovf_has_inx_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && flag_ovf |-> flag_inx);
endmodule

// File: tb/fmul_sp_tb.sv
module fmul_sp_tb;
    localparam int CLK_PERIOD = 10;
    localparam bit PIPELINED  = 1'b1;
    localparam int LAT        = PIPELINED ? 2 : 0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        rnd_mode = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_ovf, flag_unf, flag_inx;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fmul_sp #(.PIPELINED(PIPELINED)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .result(result),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inx(flag_inx)
    );

    // exact-product model: integer significand product, then one rounding step
    function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b, input logic rtz,
                                    output logic [31:0] r, output logic o, output logic u,
                                    output logic x);
        logic s, up, carry24, tiny;
        int ea, eb, k, p, eu, q, sh, s24, base;
        longint unsigned ma, mb, pr, m, rem, half, m24, rem24;
        longint val;
        s = a[31] ^ b[31];
        o = 1'b0; u = 1'b0; x = 1'b0;
        if (a[30:0] == 0 || b[30:0] == 0) begin r = {s, 31'd0}; return; end
        if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) begin
            o = 1'b1; x = 1'b1;
            r = {s, rtz ? 31'h7F7FFFFF : 31'h7F800000};
            return;
        end
        ma = (a[30:23] == 0) ? longint'(a[22:0]) : longint'({1'b1, a[22:0]});
        mb = (b[30:23] == 0) ? longint'(b[22:0]) : longint'({1'b1, b[22:0]});
        ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
        eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
        pr = ma * mb;
        k  = ea + eb - 300;
        p  = 47;
        while (p > 0 && !pr[p]) p--;
        eu = p + k + 127;
        q  = (eu >= 1) ? eu - 150 : -149;
        sh = q - k;
        up = 1'b0;
        if (sh <= 0) begin
            m = pr << (-sh); rem = 0;
        end else if (sh >= 64) begin
            m = 0; rem = pr;
        end else begin
            m = pr >> sh;
            rem = pr & ((64'd1 << sh) - 1);
            half = 64'd1 << (sh - 1);
            up = !rtz && (rem > half || (rem == half && m[0]));
        end
        x = (rem != 0);
        m = m + longint'(up);
        base = (eu >= 1) ? eu - 1 : 0;
        val = (longint'(base) << 23) + longint'(m);
        if (val >= (longint'(255) << 23)) begin
            o = 1'b1; x = 1'b1;
            r = {s, rtz ? 31'h7F7FFFFF : 31'h7F800000};
            return;
        end
        r = {s, val[30:0]};
        carry24 = 1'b0;
        s24 = p - 23;
        if (!rtz && s24 > 0) begin
            m24 = pr >> s24;
            rem24 = pr & ((64'd1 << s24) - 1);
            half = 64'd1 << (s24 - 1);
            carry24 = (m24 == 64'hFFFFFF) && (rem24 > half || (rem24 == half && m24[0]));
        end
        tiny = (eu < 0) || (eu == 0 && !carry24);
        u = tiny && x;
    endfunction

    task automatic check_out(input logic [31:0] a, input logic [31:0] b, input logic md,
                             input string tag);
        logic [31:0] er;
        logic eo, eu, ex;
        ref_mul(a, b, md, er, eo, eu, ex);
        checks++;
        if (!out_valid || result !== er || flag_ovf !== eo || flag_unf !== eu || flag_inx !== ex) begin
            failures++;
            $display("FAIL %s a=%h b=%h mode=%0d got=%h v=%b o=%b u=%b x=%b expected=%h v=1 o=%b u=%b x=%b",
                     tag, a, b, md, result, out_valid, flag_ovf, flag_unf, flag_inx, er, eo, eu, ex);
        end
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic md,
                          input string tag);
        @(negedge clk);
        op_a = a; op_b = b; rnd_mode = md; in_valid = 1'b1;
        if (LAT == 0) begin
            #1;
            check_out(a, b, md, tag);
        end else begin
            @(negedge clk);
            in_valid = 1'b0;
            repeat (LAT - 1) @(negedge clk);
            check_out(a, b, md, tag);
        end
    endtask

    function automatic logic [31:0] rand_operand();
        logic [7:0]  e;
        logic [22:0] f;
        int cls;
        cls = int'($urandom % 8);
        f = 23'($urandom);
        case (cls)
            0: begin e = 8'd0; f = 23'd0; end
            1: begin e = 8'hFF; f = 23'd0; end
            2: begin e = 8'd0; if (f == 0) f = 23'd1; end
            3: e = 8'(40 + $urandom % 50);
            4: e = 8'(150 + $urandom % 105);
            default: e = 8'(1 + $urandom % 254);
        endcase
        if ($urandom % 4 == 0) f[5:0] = 6'd0;
        return {1'($urandom), e, f};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] ra, rb;
        logic rm;
        string tag;
        logic [31:0] er;
        logic eo, eu, ex;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 32'd0 || flag_ovf || flag_unf || flag_inx) begin
            failures++;
            $display("FAIL R12 got v=%b r=%h expected v=0 r=00000000", out_valid, result);
        end

        run_op(32'h3F800000, 32'h3F800000, 1'b0, "R5");
        run_op(32'hC0000000, 32'h40400000, 1'b0, "R1");
        run_op(32'h00000000, 32'hFF800000, 1'b0, "R2");
        run_op(32'h80000000, 32'h7F800000, 1'b1, "R2");
        run_op(32'h7F800000, 32'h40000000, 1'b0, "R3");
        run_op(32'hFF800000, 32'h40000000, 1'b1, "R3");
        run_op(32'h00000001, 32'h4B000000, 1'b0, "R4");
        run_op(32'h003FFFFF, 32'h40800000, 1'b0, "R4");
        run_op(32'h3F800001, 32'h3FC00000, 1'b0, "R6");
        run_op(32'h3F800003, 32'h3FC00000, 1'b0, "R6");
        run_op(32'h3F800001, 32'h3F800001, 1'b1, "R7");
        run_op(32'h3F800001, 32'h3F800001, 1'b0, "R10");
        run_op(32'h00800000, 32'h3F000000, 1'b0, "R8");
        run_op(32'h00800001, 32'h3F000000, 1'b0, "R8");
        run_op(32'h00000003, 32'h3F000000, 1'b0, "R8");
        run_op(32'h00FFFFFF, 32'h3F000000, 1'b0, "R8");
        run_op(32'h7F000000, 32'h40000000, 1'b0, "R9");
        run_op(32'h7F000000, 32'hC0000000, 1'b1, "R9");
        run_op(32'h7F7FFFFF, 32'h3F800001, 1'b0, "R9");

        // R11: output timing relative to the input strobe
        @(negedge clk);
        op_a = 32'h40400000; op_b = 32'h40400000; rnd_mode = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (LAT == 2 && out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R11 one edge after strobe got v=%b expected v=0", out_valid);
        end
        if (LAT == 2) @(negedge clk);
        ref_mul(32'h40400000, 32'h40400000, 1'b0, er, eo, eu, ex);
        checks++;
        if (out_valid !== 1'b1 || result !== er) begin
            failures++;
            $display("FAIL R11 got v=%b r=%h expected v=1 r=%h", out_valid, result, er);
        end
        @(negedge clk);
        checks++;
        if (LAT == 2 && out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R11 valid held got v=%b expected v=0", out_valid);
        end

        for (int i = 0; i < 3000; i++) begin
            ra = rand_operand();
            rb = rand_operand();
            rm = 1'($urandom);
            ref_mul(ra, rb, rm, er, eo, eu, ex);
            tag = eo ? "R9" : (eu ? "R8" : (rm ? "R7" : "R5"));
            run_op(ra, rb, rm, tag);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule